// File: doc/BRIEF.md
# Sleep and Wake-Up Sequencer

This block sequences power-down for a small microcontroller core. The instruction decoder hands it a one-cycle sleep command. The block then either enters sleep or, if an enabled interrupt is already pending, lets the command retire as a no-op. Entering sleep does three things: it asks the external watchdog to clear its count and prescale stage, it updates two status flags, and it raises an oscillator-stop output that gates the core clock.

While the block sleeps, only interrupt sources that work without the core clock can bring it back. A watchdog expiry can also wake it, and an external master-reset request ends sleep through a full device reset. A wake condition drops the oscillator-stop output combinationally so that the clock can restart. The condition then passes through a two-flop synchronizer before the core is released.

On release, the core always executes the instruction after the sleep command. The global interrupt enable is sampled at that moment: when it is set, the block also orders a branch to the interrupt vector once that instruction completes. The two status flags keep the cause of the last reset or wake-up, so software can read it later.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, pwr_down_n and tmo_n are 1, asleep and osc_stop are 0, and wdt_clr, resume, vector_jump and dev_reset are 0.
- R2: A sleep_cmd pulse with no source pending moves the block to sleep. In the cycle after the clock edge, asleep and osc_stop are 1, pwr_down_n is 0 and tmo_n is 1, and wdt_clr is 1 for exactly that one cycle.
- R3: A source is pending when bit i is 1 in both int_en and int_flag, for any i. If any source is pending at the edge that samples sleep_cmd, the command has no effect: asleep stays 0, wdt_clr stays 0, and both flags keep their values.
- R4: Only source bits whose ASYNC_MASK bit is 1 can wake the block (default mask 4'b0111, so bit 3 cannot wake). A flag bit without its enable bit has no effect, an enable bit without its flag bit has no effect, and so does a pending source whose mask bit is 0. In each of these cases osc_stop stays 1, asleep stays 1 and no resume pulse occurs.
- R5: osc_stop falls in the same cycle in which a wake condition (an enabled, masked source flag or wdt_timeout) appears, before any clock edge.
- R6: A wake condition that appears after sleep entry produces a single-cycle resume pulse after the third rising edge that follows it, and asleep falls at that same edge.
- R7: With gie at 0 on wake, vector_jump stays 0. With gie at 1, vector_jump pulses together with resume and vector_addr equals VEC_ADDR (default 0x0004).
- R8: A wake caused by wdt_timeout clears tmo_n to 0. An interrupt wake leaves tmo_n at 1. pwr_down_n stays 0 in both cases.
- R9: mclr_req during sleep produces a one-cycle dev_reset pulse at the next edge and clears asleep, with no resume pulse. Both flags keep their values.
- R10: A clrwdt_cmd pulse while awake sets pwr_down_n and tmo_n to 1 and pulses wdt_clr for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_cmd | input | 1 | One-cycle sleep command from the decoder |
| clrwdt_cmd | input | 1 | One-cycle watchdog-clear command from the decoder |
| mclr_req | input | 1 | External master-reset request |
| wdt_timeout | input | 1 | Watchdog expiry from the external counter |
| gie | input | 1 | Global interrupt enable |
| int_en | input | N_SRC | Per-source interrupt enable bits |
| int_flag | input | N_SRC | Per-source interrupt flag bits |
| osc_stop | output | 1 | Oscillator stop enable, drops combinationally on wake |
| asleep | output | 1 | Block is in the sleep state |
| wdt_clr | output | 1 | Clear pulse for the watchdog counter and prescale stage |
| pwr_down_n | output | 1 | Power-down status flag, 0 after a completed sleep entry |
| tmo_n | output | 1 | Time-out status flag, 0 after a watchdog wake |
| resume | output | 1 | Pulse: continue at the instruction after the sleep command |
| vector_jump | output | 1 | Pulse: branch to the vector after that instruction |
| vector_addr | output | ADDR_W | Vector target, valid with vector_jump |
| dev_reset | output | 1 | Pulse: full device reset requested |

## Verification
The bench targets a pending interrupt at the moment the sleep command is sampled. A design that slept anyway would clear the watchdog and the power-down flag when it should not. It probes sources that are enabled but not flagged, flagged but not enabled, and flagged but unable to run without a clock. A design that woke on any of these would drop osc_stop or pulse resume. It samples the resume pulse one edge early and at the exact edge, so a missing or extra synchronizer stage shows up. It also checks that only a watchdog wake clears the time-out flag, and that an external reset during sleep gives a device reset instead of a resume.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } swc_state_t;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst || clr) chain <= '0;
        else            chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int               N_SRC      = 4,
  parameter logic [N_SRC-1:0] ASYNC_MASK = 4'b0111
) (
  input  logic [N_SRC-1:0] int_en,
  input  logic [N_SRC-1:0] int_flag,
  output logic             any_pending,
  output logic             clockless_wake
);
  logic [N_SRC-1:0] armed;
  always_comb begin
    armed          = int_en & int_flag;
    any_pending    = |armed;
    clockless_wake = |(armed & ASYNC_MASK);
  end
endmodule

// File: rtl/swc_status.sv
module swc_status (
  input  logic clk,
  input  logic rst,
  input  logic clr_cmd,
  input  logic enter,
  input  logic wdt_wake,
  output logic pd_n,
  output logic to_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_n <= 1'b1;
      to_n <= 1'b1;
    end else if (clr_cmd) begin
      pd_n <= 1'b1;
      to_n <= 1'b1;
    end else if (enter) begin
      pd_n <= 1'b0;
      to_n <= 1'b1;
    end else if (wdt_wake) begin
      to_n <= 1'b0;
    end
  end

  // R10
  clr_sets_flags_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (pd_n && to_n));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int               N_SRC      = 4,
  parameter logic [N_SRC-1:0] ASYNC_MASK = 4'b0111,
  parameter int               ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 13'h0004
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_cmd,
  input  logic              clrwdt_cmd,
  input  logic              mclr_req,
  input  logic              wdt_timeout,
  input  logic              gie,
  input  logic [N_SRC-1:0]  int_en,
  input  logic [N_SRC-1:0]  int_flag,
  output logic              osc_stop,
  output logic              asleep,
  output logic              wdt_clr,
  output logic              pwr_down_n,
  output logic              tmo_n,
  output logic              resume,
  output logic              vector_jump,
  output logic [ADDR_W-1:0] vector_addr,
  output logic              dev_reset
);
  localparam int SYNC_W   = 2;
  localparam int SYNC_INT = 0;
  localparam int SYNC_WDT = 1;

  swc_state_t state;
  logic any_pending, clockless_wake, wake_raw;
  logic [SYNC_W-1:0] sync_q;
  logic in_run, in_sleep, enter, clr_ok, wake_done;

  swc_wake_detect #(.N_SRC(N_SRC), .ASYNC_MASK(ASYNC_MASK)) u_detect (
    .int_en        (int_en),
    .int_flag      (int_flag),
    .any_pending   (any_pending),
    .clockless_wake(clockless_wake)
  );

  swc_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
    .clk(clk),
    .rst(rst),
    .clr(!in_sleep),
    .d  ({wdt_timeout, clockless_wake}),
    .q  (sync_q)
  );

  always_comb begin
    in_run    = (state == ST_RUN);
    in_sleep  = (state == ST_SLEEP);
    wake_raw  = clockless_wake | wdt_timeout;
    osc_stop  = in_sleep & ~wake_raw & ~mclr_req;
    enter     = in_run & sleep_cmd & ~any_pending & ~mclr_req;
    clr_ok    = in_run & clrwdt_cmd & ~sleep_cmd & ~mclr_req;
    wake_done = in_sleep & ~mclr_req & (|sync_q);
    asleep    = in_sleep;
  end

  swc_status u_status (
    .clk     (clk),
    .rst     (rst),
    .clr_cmd (clr_ok),
    .enter   (enter),
    .wdt_wake(wake_done & sync_q[SYNC_WDT]),
    .pd_n    (pwr_down_n),
    .to_n    (tmo_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      wdt_clr     <= 1'b0;
      resume      <= 1'b0;
      vector_jump <= 1'b0;
      vector_addr <= '0;
      dev_reset   <= 1'b0;
    end else begin
      wdt_clr     <= enter | clr_ok;
      resume      <= 1'b0;
      vector_jump <= 1'b0;
      vector_addr <= '0;
      dev_reset   <= mclr_req;
      case (state)
        ST_RUN: begin
          if (enter) state <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (mclr_req) begin
            state <= ST_RUN;
          end else if (wake_done) begin
            state       <= ST_RUN;
            resume      <= 1'b1;
            vector_jump <= gie;
            vector_addr <= gie ? VEC_ADDR : '0;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R2
  entry_effects_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> (wdt_clr && !pwr_down_n && tmo_n));

  // R3
  pending_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_run && sleep_cmd && any_pending) |=> (!asleep && !wdt_clr));

  // R6
  resume_from_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    resume |-> ($past(in_sleep) && !asleep));

  // R7
  vector_with_resume_chk: assert property (@(posedge clk) disable iff (rst)
    vector_jump |-> (resume && vector_addr == VEC_ADDR));

  // R9
  mclr_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_sleep && mclr_req) |=> (dev_reset && !asleep && !resume));
endmodule

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst, sleep_cmd, clrwdt_cmd, mclr_req, wdt_timeout, gie;
  logic [N-1:0] int_en, int_flag;
  logic osc_stop, asleep, wdt_clr, pwr_down_n, tmo_n, resume, vector_jump, dev_reset;
  logic [12:0] vector_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl uut (
    .clk(clk), .rst(rst), .sleep_cmd(sleep_cmd), .clrwdt_cmd(clrwdt_cmd),
    .mclr_req(mclr_req), .wdt_timeout(wdt_timeout), .gie(gie),
    .int_en(int_en), .int_flag(int_flag), .osc_stop(osc_stop), .asleep(asleep),
    .wdt_clr(wdt_clr), .pwr_down_n(pwr_down_n), .tmo_n(tmo_n), .resume(resume),
    .vector_jump(vector_jump), .vector_addr(vector_addr), .dev_reset(dev_reset)
  );

  // fields: en[12:9] flag[8:5] gie[4] wdt[3] | expected wake[2] vector[1] tmo_n[0]
  localparam logic [12:0] VECS [8] = '{
    {4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'b0010, 4'b0010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {4'b0100, 4'b0110, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {4'b1000, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'b0001, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {4'b0011, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    sleep_cmd = 0; clrwdt_cmd = 0; mclr_req = 0; wdt_timeout = 0;
    gie = 0; int_en = '0; int_flag = '0;
  endtask

  task automatic do_clrwdt();
    @(negedge clk); clrwdt_cmd = 1;
    @(negedge clk); clrwdt_cmd = 0;
  endtask

  task automatic do_sleep();
    @(negedge clk); sleep_cmd = 1;
    @(negedge clk); sleep_cmd = 0;
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 flags", {pwr_down_n, tmo_n}, 2'b11);
    chk("R1 state", {asleep, osc_stop}, 2'b00);
    chk("R1 pulses", {wdt_clr, resume, vector_jump, dev_reset}, 4'b0000);

    foreach (VECS[i]) begin
      do_clrwdt();
      do_sleep();
      chk("R2 entry", {asleep, osc_stop, pwr_down_n, tmo_n, wdt_clr}, 5'b11011);
      @(negedge clk);
      chk("R2 clr single", wdt_clr, 1'b0);
      int_en = VECS[i][12:9]; int_flag = VECS[i][8:5];
      gie = VECS[i][4]; wdt_timeout = VECS[i][3];
      #1;
      chk(VECS[i][2] ? "R5 osc drop" : "R4 osc held", osc_stop, !VECS[i][2]);
      @(negedge clk); @(negedge clk);
      chk("R6 not early", resume, 1'b0);
      @(negedge clk);
      if (VECS[i][2]) begin
        chk("R6 resume", {resume, asleep}, 2'b10);
        chk("R7 vector", {vector_jump, vector_addr}, {VECS[i][1], VECS[i][1] ? 13'h0004 : 13'h0});
        chk("R8 flags", {pwr_down_n, tmo_n}, {1'b0, VECS[i][0]});
        @(negedge clk);
        chk("R6 single", resume, 1'b0);
        idle();
      end else begin
        chk("R4 stays asleep", {asleep, osc_stop, resume}, 3'b110);
        idle();
        mclr_req = 1;
        @(negedge clk);
        mclr_req = 0;
        chk("R9 reset exit", {dev_reset, asleep, resume}, 3'b100);
        chk("R9 flags", {pwr_down_n, tmo_n}, 2'b01);
      end
    end

    // R3: pending source (also a clock-dependent one) turns sleep into a no-op
    do_clrwdt();
    int_en = 4'b1000; int_flag = 4'b1000;
    do_sleep();
    chk("R3 noop state", {asleep, wdt_clr}, 2'b00);
    chk("R3 noop flags", {pwr_down_n, tmo_n}, 2'b11);
    idle();
    @(negedge clk);
    chk("R3 later", asleep, 1'b0);

    // R10: clear after a sleep/reset cycle restores flags
    do_sleep();
    mclr_req = 1; @(negedge clk); mclr_req = 0;
    chk("R9 dev_reset", dev_reset, 1'b1);
    @(negedge clk); clrwdt_cmd = 1;
    @(negedge clk); clrwdt_cmd = 0;
    chk("R10 clear", {wdt_clr, pwr_down_n, tmo_n}, 3'b111);
    @(negedge clk);
    chk("R10 single", wdt_clr, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule